// File: doc/BRIEF.md
# Grouped Wavefront Issue Scheduler

This block decides, every clock cycle, which resident hardware thread context (a wavefront) of a heavily multithreaded vector core may issue its next instruction. The contexts live in four fixed groups of up to ten slots each. The scheduler moves through the groups in turn, and inside a group it moves round-robin through the wavefronts that are ready.

A wavefront that has started a long-latency texture lookup is parked until its lookup finishes. While it is parked, the other wavefronts keep the issue slot busy. Each wavefront also carries a 64-lane execution mask. The mask travels with the grant, together with a flag that is high when every lane is off. When that flag is high, the issued vector operation does nothing and the flag can steer a branch.

Software-visible state is limited to allocation, retirement, stall marking and mask writes. Decode, register files and execution units sit outside the block.

Top module: `wfs_sched`

## Requirements
- R1: After reset no wavefront is resident, `grantValid` is low, and `allocAck` and `allocErr` are low.
- R2: A request on `allocValid` for a group with a free slot takes the lowest-numbered free slot of that group. On the next cycle `allocAck` is high and `allocId` holds the id. An id is 6 bits: bits [5:4] are the group and bits [3:0] are the slot, 0 to 9. The new wavefront starts ready, with `allocMask` as its lane mask.
- R3: A request on `allocValid` for a group whose ten slots are all occupied is refused. Occupancy does not change, `allocAck` stays low, and `allocErr` is high for exactly one cycle.
- R4: The groups are visited in rotation starting just after the group granted last. A group with no ready wavefront is passed over in the same cycle.
- R5: Within a group, the chosen wavefront is the first ready slot after the slot granted last in that group, wrapping from slot 9 to slot 0.
- R6: After `stallSetValid` names a resident wavefront, that wavefront is not granted until `stallClrValid` names it. From then on it can be granted again.
- R7: A stall-clear naming a slot that is not resident, or a slot number of 10 or more, has no effect on grants.
- R8: At most one wavefront is granted per cycle. When no resident wavefront is ready, `grantValid` is low.
- R9: `grantMask` carries the granted wavefront's lane mask. A `maskWrValid` write replaces that mask. `grantMaskZero` is high exactly when the granted mask is all zeros.
- R10: A retired wavefront is no longer granted. Its slot becomes free for a later allocation, which resets the slot's mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocValid | input | 1 | Allocation request |
| allocGroup | input | 2 | Group to allocate into |
| allocMask | input | 64 | Initial lane mask of the new wavefront |
| allocAck | output | 1 | Allocation accepted last cycle |
| allocId | output | 6 | Id given to the accepted wavefront |
| allocErr | output | 1 | One-cycle pulse: allocation refused, group full |
| retireValid | input | 1 | Retire request |
| retireId | input | 6 | Wavefront to retire |
| stallSetValid | input | 1 | Park a wavefront (texture lookup started) |
| stallSetId | input | 6 | Wavefront to park |
| stallClrValid | input | 1 | Unpark a wavefront (lookup done) |
| stallClrId | input | 6 | Wavefront to unpark |
| maskWrValid | input | 1 | Lane mask write |
| maskWrId | input | 6 | Wavefront whose mask is written |
| maskWrData | input | 64 | New lane mask |
| grantValid | output | 1 | A wavefront issues this cycle |
| grantId | output | 6 | Id of the issuing wavefront |
| grantMask | output | 64 | Lane mask of the issuing wavefront |
| grantMaskZero | output | 1 | Issuing wavefront has every lane disabled |

## Verification
A wrong rotation pointer or last-slot pointer shows up in the grant sequence within one pass over the groups. The bench therefore compares every cycle of a mixed-occupancy pattern against an exact id sequence. A stuck stall or valid bit appears as soon as every other wavefront is parked: `grantValid` is then either wrongly high or wrongly low on the very next cycle. Mask corruption and lost refusals appear directly on `grantMask`, `allocId` and `allocErr` one cycle after the causing request.

// File: rtl/wfs_pkg.sv
package wfs_pkg;
  localparam int NUM_GROUPS      = 4;
  localparam int SLOTS_PER_GROUP = 10;
  localparam int LANES           = 64;
  localparam int GROUP_W         = $clog2(NUM_GROUPS);
  localparam int SLOT_W          = $clog2(SLOTS_PER_GROUP);
  localparam int ID_W            = GROUP_W + SLOT_W;
  localparam int TOTAL           = NUM_GROUPS * SLOTS_PER_GROUP;
  localparam int FLAT_W          = $clog2(TOTAL);

  // strobes from the control half to the state half
  typedef struct packed {
    logic              grantFire;
    logic [ID_W-1:0]   grantId;
    logic              allocWe;
    logic [ID_W-1:0]   allocId;
    logic              allocRefuse;
  } ctrlStrobes_t;

  function automatic logic idOk(logic [ID_W-1:0] id);
    return (int'(id[SLOT_W-1:0]) < SLOTS_PER_GROUP) &&
           (int'(id[ID_W-1:SLOT_W]) < NUM_GROUPS);
  endfunction

  function automatic logic [FLAT_W-1:0] flatIdx(logic [ID_W-1:0] id);
    return FLAT_W'(int'(id[ID_W-1:SLOT_W]) * SLOTS_PER_GROUP + int'(id[SLOT_W-1:0]));
  endfunction
endpackage

// File: rtl/wfs_rr_pick.sv
module wfs_rr_pick #(
  parameter int SLOTS = 10,
  localparam int SW = $clog2(SLOTS)
) (
  input  logic [SLOTS-1:0] req,
  input  logic [SW-1:0]    last,
  output logic             hit,
  output logic [SW-1:0]    idx
);
  // first requester strictly after 'last', wrapping
  always_comb begin
    int cand;
    hit = 1'b0;
    idx = '0;
    cand = 0;
    for (int k = 1; k <= SLOTS; k++) begin
      cand = int'(last) + k;
      if (cand >= SLOTS) cand = cand - SLOTS;
      if (!hit && req[cand]) begin
        hit = 1'b1;
        idx = SW'(cand);
      end
    end
  end
endmodule

// File: rtl/wfs_ctrl.sv
module wfs_ctrl import wfs_pkg::*; (
  input  logic               clk,
  input  logic               rstN,
  input  logic [TOTAL-1:0]   readyVec,
  input  logic [TOTAL-1:0]   validVec,
  input  logic               allocValid,
  input  logic [GROUP_W-1:0] allocGroup,
  output ctrlStrobes_t       strobes
);
  logic [NUM_GROUPS-1:0] groupHit;
  logic [SLOT_W-1:0]     groupSlot [NUM_GROUPS];
  logic [SLOT_W-1:0]     lastSlotQ [NUM_GROUPS];
  logic [GROUP_W-1:0]    groupPtrQ;
  logic [GROUP_W-1:0]    selGroup;
  logic [GROUP_W-1:0]    nextGroup;
  logic                  selFound;

  genvar g;
  for (g = 0; g < NUM_GROUPS; g++) begin : gen_grp
    wfs_rr_pick #(.SLOTS(SLOTS_PER_GROUP)) u_pick (
      .req  (readyVec[g*SLOTS_PER_GROUP +: SLOTS_PER_GROUP]),
      .last (lastSlotQ[g]),
      .hit  (groupHit[g]),
      .idx  (groupSlot[g])
    );
  end

  // rotate over groups starting at the pointer; empty groups pass in-cycle
  always_comb begin
    int gi;
    selFound = 1'b0;
    selGroup = '0;
    gi = 0;
    for (int k = 0; k < NUM_GROUPS; k++) begin
      gi = int'(groupPtrQ) + k;
      if (gi >= NUM_GROUPS) gi = gi - NUM_GROUPS;
      if (!selFound && groupHit[gi]) begin
        selFound = 1'b1;
        selGroup = GROUP_W'(gi);
      end
    end
  end

  assign nextGroup = (int'(selGroup) == NUM_GROUPS - 1) ? '0 : selGroup + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      groupPtrQ <= '0;
      for (int k = 0; k < NUM_GROUPS; k++) lastSlotQ[k] <= SLOT_W'(SLOTS_PER_GROUP - 1);
    end else if (selFound) begin
      lastSlotQ[selGroup] <= groupSlot[selGroup];
      groupPtrQ           <= nextGroup;
    end
  end

  // lowest free slot in the requested group
  logic [SLOTS_PER_GROUP-1:0] groupValid;
  logic                       freeFound;
  logic [SLOT_W-1:0]          freeSlot;

  always_comb begin
    groupValid = validVec[int'(allocGroup)*SLOTS_PER_GROUP +: SLOTS_PER_GROUP];
    freeFound  = 1'b0;
    freeSlot   = '0;
    for (int s = 0; s < SLOTS_PER_GROUP; s++) begin
      if (!freeFound && !groupValid[s]) begin
        freeFound = 1'b1;
        freeSlot  = SLOT_W'(s);
      end
    end
  end

  assign strobes.grantFire   = selFound;
  assign strobes.grantId     = {selGroup, groupSlot[selGroup]};
  assign strobes.allocWe     = allocValid && freeFound;
  assign strobes.allocId     = {allocGroup, freeSlot};
  assign strobes.allocRefuse = allocValid && !freeFound;

  // a grant only ever lands on a wavefront the state half reports ready
  assert_grant_ready_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.grantFire |-> readyVec[flatIdx(strobes.grantId)]);

  // nothing ready anywhere means no issue this cycle
  assert_idle_no_grant_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(|readyVec) |-> !strobes.grantFire);
endmodule

// File: rtl/wfs_state.sv
module wfs_state import wfs_pkg::*; (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [LANES-1:0] allocMask,
  input  logic             retireValid,
  input  logic [ID_W-1:0]  retireId,
  input  logic             stallSetValid,
  input  logic [ID_W-1:0]  stallSetId,
  input  logic             stallClrValid,
  input  logic [ID_W-1:0]  stallClrId,
  input  logic             maskWrValid,
  input  logic [ID_W-1:0]  maskWrId,
  input  logic [LANES-1:0] maskWrData,
  output logic [TOTAL-1:0] readyVec,
  output logic [TOTAL-1:0] validVec,
  output logic [LANES-1:0] grantMask
);
  logic [TOTAL-1:0]  validQ;
  logic [TOTAL-1:0]  stallQ;
  logic [LANES-1:0]  maskQ [TOTAL];
  logic [FLAT_W-1:0] retireFlat, setFlat, clrFlat, maskFlat, allocFlat, grantFlat;

  assign retireFlat = flatIdx(retireId);
  assign setFlat    = flatIdx(stallSetId);
  assign clrFlat    = flatIdx(stallClrId);
  assign maskFlat   = flatIdx(maskWrId);
  assign allocFlat  = flatIdx(strobes.allocId);
  assign grantFlat  = flatIdx(strobes.grantId);

  genvar i;
  for (i = 0; i < TOTAL; i++) begin : gen_ent
    logic hitAlloc, hitRetire, hitSet, hitClr, hitMask;
    assign hitAlloc  = strobes.allocWe && (allocFlat == FLAT_W'(i));
    assign hitRetire = retireValid   && idOk(retireId)   && (retireFlat == FLAT_W'(i));
    assign hitSet    = stallSetValid && idOk(stallSetId) && (setFlat    == FLAT_W'(i));
    assign hitClr    = stallClrValid && idOk(stallClrId) && (clrFlat    == FLAT_W'(i));
    assign hitMask   = maskWrValid   && idOk(maskWrId)   && (maskFlat   == FLAT_W'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        validQ[i] <= 1'b0;
        stallQ[i] <= 1'b0;
        maskQ[i]  <= '0;
      end else if (hitAlloc) begin
        validQ[i] <= 1'b1;
        stallQ[i] <= 1'b0;
        maskQ[i]  <= allocMask;
      end else begin
        if (hitRetire) validQ[i] <= 1'b0;
        if (hitSet && validQ[i])      stallQ[i] <= 1'b1;
        else if (hitClr && validQ[i]) stallQ[i] <= 1'b0;
        if (hitMask && validQ[i])     maskQ[i]  <= maskWrData;
      end
    end
  end

  assign validVec  = validQ;
  assign readyVec  = validQ & ~stallQ;
  assign grantMask = strobes.grantFire ? maskQ[grantFlat] : '0;

  // an accepted allocation leaves its slot resident and ready
  assert_alloc_lands_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.allocWe |=> validQ[$past(allocFlat)] && !stallQ[$past(allocFlat)]);

  // a refused allocation leaves occupancy untouched
  assert_refuse_no_change_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.allocRefuse && !retireValid |=> $stable(validQ));

  // retiring a resident wavefront frees its slot
  assert_retire_frees_R10: assert property (@(posedge clk) disable iff (!rstN)
    retireValid && idOk(retireId) && validQ[retireFlat] |=> !validQ[$past(retireFlat)]);
endmodule

// File: rtl/wfs_sched.sv
module wfs_sched import wfs_pkg::*; (
  input  logic               clk,
  input  logic               rstN,
  input  logic               allocValid,
  input  logic [GROUP_W-1:0] allocGroup,
  input  logic [LANES-1:0]   allocMask,
  output logic               allocAck,
  output logic [ID_W-1:0]    allocId,
  output logic               allocErr,
  input  logic               retireValid,
  input  logic [ID_W-1:0]    retireId,
  input  logic               stallSetValid,
  input  logic [ID_W-1:0]    stallSetId,
  input  logic               stallClrValid,
  input  logic [ID_W-1:0]    stallClrId,
  input  logic               maskWrValid,
  input  logic [ID_W-1:0]    maskWrId,
  input  logic [LANES-1:0]   maskWrData,
  output logic               grantValid,
  output logic [ID_W-1:0]    grantId,
  output logic [LANES-1:0]   grantMask,
  output logic               grantMaskZero
);
  ctrlStrobes_t     strobes;
  logic [TOTAL-1:0] readyVec;
  logic [TOTAL-1:0] validVec;

  wfs_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .readyVec   (readyVec),
    .validVec   (validVec),
    .allocValid (allocValid),
    .allocGroup (allocGroup),
    .strobes    (strobes)
  );

  wfs_state u_state (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .allocMask     (allocMask),
    .retireValid   (retireValid),
    .retireId      (retireId),
    .stallSetValid (stallSetValid),
    .stallSetId    (stallSetId),
    .stallClrValid (stallClrValid),
    .stallClrId    (stallClrId),
    .maskWrValid   (maskWrValid),
    .maskWrId      (maskWrId),
    .maskWrData    (maskWrData),
    .readyVec      (readyVec),
    .validVec      (validVec),
    .grantMask     (grantMask)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      allocAck <= 1'b0;
      allocErr <= 1'b0;
      allocId  <= '0;
    end else begin
      allocAck <= strobes.allocWe;
      allocErr <= strobes.allocRefuse;
      if (strobes.allocWe) allocId <= strobes.allocId;
    end
  end

  assign grantValid    = strobes.grantFire;
  assign grantId       = strobes.grantId;
  assign grantMaskZero = grantValid && (grantMask == '0);
endmodule

// File: tb/wfs_sched_tb.sv
module wfs_sched_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rstN;
  logic        allocValid;
  logic [1:0]  allocGroup;
  logic [63:0] allocMask;
  logic        allocAck;
  logic [5:0]  allocId;
  logic        allocErr;
  logic        retireValid;
  logic [5:0]  retireId;
  logic        stallSetValid;
  logic [5:0]  stallSetId;
  logic        stallClrValid;
  logic [5:0]  stallClrId;
  logic        maskWrValid;
  logic [5:0]  maskWrId;
  logic [63:0] maskWrData;
  logic        grantValid;
  logic [5:0]  grantId;
  logic [63:0] grantMask;
  logic        grantMaskZero;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wfs_sched u_dut (.*);

  // fields: allocV, allocG[2], expAck, expAllocId[6], expGV, expGid[6]
  localparam int NVEC = 11;
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b1, 2'd0, 1'b1, 6'h00, 1'b1, 6'h00},
    {1'b1, 2'd0, 1'b1, 6'h01, 1'b1, 6'h01},
    {1'b1, 2'd0, 1'b1, 6'h02, 1'b1, 6'h02},
    {1'b1, 2'd2, 1'b1, 6'h20, 1'b1, 6'h20},
    {1'b0, 2'd0, 1'b0, 6'h00, 1'b1, 6'h00},
    {1'b0, 2'd0, 1'b0, 6'h00, 1'b1, 6'h20},
    {1'b0, 2'd0, 1'b0, 6'h00, 1'b1, 6'h01},
    {1'b0, 2'd0, 1'b0, 6'h00, 1'b1, 6'h20},
    {1'b0, 2'd0, 1'b0, 6'h00, 1'b1, 6'h02},
    {1'b0, 2'd0, 1'b0, 6'h00, 1'b1, 6'h20},
    {1'b0, 2'd0, 1'b0, 6'h00, 1'b1, 6'h00}
  };

  function automatic logic [63:0] mk(logic [5:0] id);
    return {8{2'b01, id}};
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    allocValid = 0; allocGroup = 0; allocMask = 0;
    retireValid = 0; retireId = 0;
    stallSetValid = 0; stallSetId = 0;
    stallClrValid = 0; stallClrId = 0;
    maskWrValid = 0; maskWrId = 0; maskWrData = 0;
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    idle();
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    tick();
    chk("R1 grantValid after reset", grantValid, 0);
    chk("R1 allocAck after reset", allocAck, 0);
    chk("R1 allocErr after reset", allocErr, 0);

    // table walk: allocation into groups 0 and 2, then rotation/round-robin (R4, R5)
    for (int v = 0; v < NVEC; v++) begin
      allocValid = VEC[v][16];
      allocGroup = VEC[v][15:14];
      allocMask  = mk(VEC[v][12:7]);
      tick();
      idle();
      chk($sformatf("R2 allocAck vec%0d", v), allocAck, VEC[v][13]);
      if (VEC[v][13]) chk($sformatf("R2 allocId vec%0d", v), allocId, VEC[v][12:7]);
      chk($sformatf("R8 grantValid vec%0d", v), grantValid, VEC[v][6]);
      chk($sformatf("R4 R5 grantId vec%0d", v), grantId, VEC[v][5:0]);
    end

    // R6: park 0x20; only group 0 issues
    stallSetValid = 1; stallSetId = 6'h20;
    tick(); idle();
    for (int c = 0; c < 6; c++) begin
      chk($sformatf("R6 parked not granted c%0d", c),
          {grantValid, (grantId == 6'h20)}, 2'b10);
      tick();
    end

    // park the rest; nothing ready (R8)
    stallSetValid = 1; stallSetId = 6'h00; tick();
    stallSetId = 6'h02; tick();
    stallSetId = 6'h01; tick(); idle();
    chk("R8 no grant when all parked", grantValid, 0);

    // R7: clears that name a free slot or a bad slot number do nothing
    stallClrValid = 1; stallClrId = 6'h15; tick(); idle();
    chk("R7 clear free slot ignored", grantValid, 0);
    stallClrValid = 1; stallClrId = 6'h0C; tick(); idle();
    chk("R7 clear bad slot ignored", grantValid, 0);

    // R6 release; only 0x01 ready so it issues every cycle
    stallClrValid = 1; stallClrId = 6'h01; tick(); idle();
    chk("R6 unparked grantValid", grantValid, 1);
    chk("R6 unparked grantId", grantId, 6'h01);
    chk("R9 grantMask from alloc", grantMask, mk(6'h01));
    chk("R9 grantMaskZero low", grantMaskZero, 0);
    tick();
    chk("R8 single ready repeats", grantId, 6'h01);

    // R9 mask writes
    maskWrValid = 1; maskWrId = 6'h01; maskWrData = 64'h0; tick(); idle();
    chk("R9 mask written zero", grantMask, 64'h0);
    chk("R9 grantMaskZero high", grantMaskZero, 1);
    maskWrValid = 1; maskWrId = 6'h01; maskWrData = 64'h8000_0000_0000_0001; tick(); idle();
    chk("R9 mask written value", grantMask, 64'h8000_0000_0000_0001);
    chk("R9 grantMaskZero low again", grantMaskZero, 0);

    // R10 retire and reuse of the slot
    retireValid = 1; retireId = 6'h01; tick(); idle();
    chk("R10 retired not granted", grantValid, 0);
    allocValid = 1; allocGroup = 2'd0; allocMask = mk(6'h01); tick(); idle();
    chk("R10 freed slot reused", allocId, 6'h01);
    chk("R2 realloc ack", allocAck, 1);
    chk("R10 reused slot granted", grantId, 6'h01);
    chk("R10 mask reset on realloc", grantMask, mk(6'h01));

    // R3: fill group 3, then one more
    for (int s = 0; s < 10; s++) begin
      allocValid = 1; allocGroup = 2'd3; allocMask = mk({2'd3, 4'(s)}); tick(); idle();
      chk($sformatf("R2 group3 slot%0d id", s), allocId, {2'd3, 4'(s)});
    end
    allocValid = 1; allocGroup = 2'd3; allocMask = 64'hFFFF; tick(); idle();
    chk("R3 full group allocErr", allocErr, 1);
    chk("R3 full group no ack", allocAck, 0);
    tick();
    chk("R3 allocErr lasts one cycle", allocErr, 0);

    summary();
    $finish;
  end
endmodule